// File: doc/BRIEF.md
# Card Controller Data FIFO

This block is the byte buffer between the register interface used by the host or DMA engine and the 16-bit serial data path of a memory-card controller. It holds 64 bytes. One direction input sets the roles of the two sides. In transmit, the host or DMA fills the buffer and the transmit shifter drains it one 16-bit word at a time. In receive, the receive shifter fills it one 16-bit word at a time and the host or DMA drains it.

Each host access moves 1 to 4 bytes, selected by a 2-bit access-width code. The full and empty flags are judged against that width, so a host that sees "not full" can always complete a whole write, and a host that sees "not empty" can always complete a whole read. A synchronous clear input empties the buffer before a transfer.

The block counts the bytes that the shifter side moves. Each time that count reaches 256 or 512 bits, it raises a one-cycle event pulse. This pulse serves as the DMA request or the ready interrupt. In transmit, the host uses it as the cue to refill the buffer.

Top module: `card_data_fifo`

## Requirements
- R1: After rst_ni is asserted, or in the cycle after fifo_rst_i is high, the buffer holds no bytes: empty_o=1, full_o=0, err_o=0 and evt_o=0.
- R2: The access-width code acc_w_i sets the bytes per host access: 00=4, 01=3, 10=2, 11=1. A write stores bytes from host_wdata_i starting at bits 7:0, lowest lane first. host_rdata_o returns the oldest byte in bits 7:0 and the next ones in higher lanes. Lanes at or above the width read as zero.
- R3: full_o is 1 exactly when the free bytes (64 minus the stored bytes) are fewer than the selected access width.
- R4: empty_o is 1 exactly when the stored bytes are fewer than the selected access width.
- R5: A host write while full_o=1 (transmit) or a host read while empty_o=1 (receive) changes nothing in the buffer. It sets err_o, which stays at 1 until fifo_rst_i.
- R6: With dir_tx_i=1, tx_load_o is 1 in any cycle where tx_ready_i=1 and at least 2 bytes are stored. tx_word_o is {second-oldest byte, oldest byte}, and those 2 bytes leave. A host read in transmit has no effect and raises no error.
- R7: With dir_tx_i=0, rx_take_o is 1 in any cycle where rx_ready_i=1 and at least 2 bytes are free. In that cycle rx_word_i[7:0] is stored before rx_word_i[15:8]. A host write in receive has no effect and raises no error.
- R8: evt_o is a one-cycle pulse. It appears in the cycle after the shifter transfer that brings the bytes moved by the shifter to 32 (thr_512_i=0) or 64 (thr_512_i=1). The count then restarts from zero.
- R9: The shifter byte count is cleared by fifo_rst_i and by any change of dir_tx_i. A transfer in the first cycle of the new direction counts.
- R10: fifo_rst_i has priority: in a cycle where it is high, no host access or shifter transfer takes effect, and tx_load_o and rx_take_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_rst_i | input | 1 | Synchronous buffer clear |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| acc_w_i | input | 2 | Host access-width code |
| thr_512_i | input | 1 | Event threshold: 0 = 256 bits, 1 = 512 bits |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data, little-endian lanes |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 32 | Host read data (oldest bytes) |
| full_o | output | 1 | No room for one full-width access |
| empty_o | output | 1 | Not enough bytes for one full-width access |
| err_o | output | 1 | Sticky overflow/underflow flag |
| tx_ready_i | input | 1 | Transmit shifter ready for a word |
| tx_load_o | output | 1 | Word handed to the transmit shifter this cycle |
| tx_word_o | output | 16 | Word for the transmit shifter |
| rx_ready_i | input | 1 | Receive shifter holds a word |
| rx_word_i | input | 16 | Word from the receive shifter |
| rx_take_o | output | 1 | Receive word accepted this cycle |
| evt_o | output | 1 | Threshold event pulse |

## Verification
The bench builds the block with its defaults: 64 bytes of storage, 4-byte host lanes, 2-byte shifter words, and thresholds of 32 and 64 bytes. With these values the buffer fills in 16 full-width writes, so the bench reaches the full flag, pointer wrap and both thresholds within a few hundred cycles. The 3-byte width leaves remainders that do not divide the depth, which tests the flag margins at odd counts. A behavioural queue model, stepped every cycle, predicts the flags, data words, strobes, error and event for each of the four width codes and in both directions.

// File: rtl/card_fifo_pkg.sv
`timescale 1ns/1ps
package card_fifo_pkg;
  // access-width code 00..11 -> max_b..max_b-3 bytes, never below one
  function automatic int acc_bytes(input logic [1:0] code, input int max_b);
    int n;
    n = max_b - int'(code);
    return (n < 1) ? 1 : n;
  endfunction
endpackage

// File: rtl/cfifo_store.sv
`timescale 1ns/1ps
module cfifo_store #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = $clog2(LANES) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      waddr_i,
  input  logic [NW-1:0]      wr_n_i,
  input  logic [LANES*8-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [LANES*8-1:0] peek_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (NW'(k) < wr_n_i) mem[waddr_i + AW'(k)] <= wdata_i[k*8 +: 8];
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    logic [AW-1:0] a;
    assign a = raddr_i + AW'(k);
    assign peek_o[k*8 +: 8] = mem[a];
  end
endmodule

// File: rtl/cfifo_flags.sv
`timescale 1ns/1ps
module cfifo_flags
  import card_fifo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int HOST_BYTES = 4,
  parameter int WORD_BYTES = 2,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int NW = $clog2(HOST_BYTES) + 1
) (
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    code_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [NW-1:0] nbytes_o,
  output logic          room_word_o,
  output logic          have_word_o
);
  logic [CW-1:0] free_b;
  logic [CW-1:0] need;

  assign free_b      = CW'(DEPTH) - count_i;
  assign need        = CW'(acc_bytes(code_i, HOST_BYTES));
  assign nbytes_o    = NW'(need);
  assign full_o      = free_b < need;
  assign empty_o     = count_i < need;
  assign room_word_o = free_b >= CW'(WORD_BYTES);
  assign have_word_o = count_i >= CW'(WORD_BYTES);
endmodule

// File: rtl/cfifo_evt.sv
`timescale 1ns/1ps
module cfifo_evt #(
  parameter int LO_BYTES = 32,
  parameter int HI_BYTES = 64,
  parameter int STEP     = 2,
  localparam int CNTW = $clog2(HI_BYTES + STEP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic restart_i,
  input  logic move_i,
  input  logic thr_hi_i,
  output logic evt_o
);
  logic [CNTW-1:0] cnt_q, base, nxt, lim;

  assign base = restart_i ? '0 : cnt_q;
  assign nxt  = base + CNTW'(STEP);
  assign lim  = thr_hi_i ? CNTW'(HI_BYTES) : CNTW'(LO_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (move_i) begin
        if (nxt >= lim) begin
          evt_o <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= nxt;
        end
      end else begin
        cnt_q <= base;
      end
    end
  end
endmodule

// File: rtl/card_data_fifo.sv
`timescale 1ns/1ps
module card_data_fifo #(
  parameter int DEPTH        = 64,
  parameter int HOST_BYTES   = 4,
  parameter int WORD_BYTES   = 2,
  parameter int THR_LO_BYTES = 32,
  parameter int THR_HI_BYTES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fifo_rst_i,
  input  logic                    dir_tx_i,
  input  logic [1:0]              acc_w_i,
  input  logic                    thr_512_i,
  input  logic                    host_wr_i,
  input  logic [HOST_BYTES*8-1:0] host_wdata_i,
  input  logic                    host_rd_i,
  output logic [HOST_BYTES*8-1:0] host_rdata_o,
  output logic                    full_o,
  output logic                    empty_o,
  output logic                    err_o,
  input  logic                    tx_ready_i,
  output logic                    tx_load_o,
  output logic [WORD_BYTES*8-1:0] tx_word_o,
  input  logic                    rx_ready_i,
  input  logic [WORD_BYTES*8-1:0] rx_word_i,
  output logic                    rx_take_o,
  output logic                    evt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int NW = $clog2(HOST_BYTES) + 1;
  localparam int HW = HOST_BYTES * 8;
  localparam int WW = WORD_BYTES * 8;

  logic [PW-1:0] wptr_q, rptr_q, count;
  logic [NW-1:0] nbytes, push_n, pop_n;
  logic [HW-1:0] push_data, peek;
  logic          room_word, have_word, dir_q;
  logic          wr_req, rd_req, wr_ok, rd_ok, bad_acc;

  assign count = wptr_q - rptr_q;

  cfifo_flags #(.DEPTH(DEPTH), .HOST_BYTES(HOST_BYTES), .WORD_BYTES(WORD_BYTES)) u_flags (
    .count_i(count), .code_i(acc_w_i), .full_o(full_o), .empty_o(empty_o),
    .nbytes_o(nbytes), .room_word_o(room_word), .have_word_o(have_word)
  );

  // producer/consumer roles by direction
  assign wr_req    = dir_tx_i & host_wr_i & ~fifo_rst_i;
  assign rd_req    = ~dir_tx_i & host_rd_i & ~fifo_rst_i;
  assign wr_ok     = wr_req & ~full_o;
  assign rd_ok     = rd_req & ~empty_o;
  assign bad_acc   = (wr_req & full_o) | (rd_req & empty_o);
  assign tx_load_o = dir_tx_i & tx_ready_i & have_word & ~fifo_rst_i;
  assign rx_take_o = ~dir_tx_i & rx_ready_i & room_word & ~fifo_rst_i;

  always_comb begin
    push_n    = '0;
    push_data = host_wdata_i;
    if (wr_ok) begin
      push_n = nbytes;
    end else if (rx_take_o) begin
      push_n    = NW'(WORD_BYTES);
      push_data = HW'(rx_word_i);
    end
  end

  assign pop_n = rd_ok ? nbytes : (tx_load_o ? NW'(WORD_BYTES) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      err_o  <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      dir_q <= dir_tx_i;
      if (fifo_rst_i) begin
        wptr_q <= '0;
        rptr_q <= '0;
        err_o  <= 1'b0;
      end else begin
        wptr_q <= wptr_q + PW'(push_n);
        rptr_q <= rptr_q + PW'(pop_n);
        if (bad_acc) err_o <= 1'b1;
      end
    end
  end

  cfifo_store #(.DEPTH(DEPTH), .LANES(HOST_BYTES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .waddr_i(wptr_q[AW-1:0]), .wr_n_i(push_n), .wdata_i(push_data),
    .raddr_i(rptr_q[AW-1:0]), .peek_o(peek)
  );

  for (genvar k = 0; k < HOST_BYTES; k++) begin : g_rlane
    assign host_rdata_o[k*8 +: 8] = (NW'(k) < nbytes) ? peek[k*8 +: 8] : 8'h00;
  end

  assign tx_word_o = peek[WW-1:0];

  cfifo_evt #(.LO_BYTES(THR_LO_BYTES), .HI_BYTES(THR_HI_BYTES), .STEP(WORD_BYTES)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(fifo_rst_i),
    .restart_i(dir_tx_i != dir_q), .move_i(tx_load_o | rx_take_o),
    .thr_hi_i(thr_512_i), .evt_o(evt_o)
  );
endmodule

// File: rtl/card_data_fifo_chk.sv
`timescale 1ns/1ps
module card_data_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fifo_rst_i,
  input logic dir_tx_i,
  input logic host_wr_i,
  input logic host_rd_i,
  input logic full_o,
  input logic empty_o,
  input logic err_o,
  input logic tx_ready_i,
  input logic tx_load_o,
  input logic rx_ready_i,
  input logic rx_take_o,
  input logic evt_o
);
  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> (empty_o && !full_o && !err_o && !evt_o));
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_tx_i && host_wr_i && full_o && !fifo_rst_i) |=> err_o);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_tx_i && host_rd_i && empty_o && !fifo_rst_i) |=> err_o);
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !fifo_rst_i) |=> err_o);
  assert_tx_side_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> (dir_tx_i && tx_ready_i));
  assert_rx_side_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_take_o |-> (!dir_tx_i && rx_ready_i));
  assert_one_shifter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_load_o, rx_take_o}));
  assert_evt_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  assert_rst_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |-> (!tx_load_o && !rx_take_o));
endmodule

bind card_data_fifo card_data_fifo_chk u_chk (.*);

// File: tb/tb_card_data_fifo.sv
`timescale 1ns/1ps
module tb_card_data_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_rst_i = 1'b0, dir_tx_i = 1'b0, thr_512_i = 1'b0;
  logic [1:0]  acc_w_i = 2'b00;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0, tx_ready_i = 1'b0, rx_ready_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic [15:0] rx_word_i = '0;
  logic [31:0] host_rdata_o;
  logic [15:0] tx_word_o;
  logic        full_o, empty_o, err_o, tx_load_o, rx_take_o, evt_o;

  always #2.5 clk_i = ~clk_i;

  card_data_fifo dut (.*);

  int n_tests = 0, n_fail = 0;
  logic [7:0] q[$];
  bit m_err = 0, m_evt = 0, m_dir = 0;
  int m_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // inputs are set; compare outputs, clock once, advance model
  task automatic step();
    int w, sz, fr, base;
    bit moved;
    logic [31:0] er;
    #1;
    w = 4 - int'(acc_w_i);
    sz = q.size();
    fr = 64 - sz;
    chk(32'(full_o), 32'(fr < w), "R3 full");
    chk(32'(empty_o), 32'(sz < w), "R4 empty");
    chk(32'(err_o), 32'(m_err), "R5 err");
    chk(32'(evt_o), 32'(m_evt), "R8,R9 evt");
    chk(32'(tx_load_o), 32'(!fifo_rst_i && dir_tx_i && tx_ready_i && sz >= 2), "R6,R10 tx_load");
    chk(32'(rx_take_o), 32'(!fifo_rst_i && !dir_tx_i && rx_ready_i && fr >= 2), "R7,R10 rx_take");
    if (tx_load_o && sz >= 2) chk(32'(tx_word_o), {16'h0, q[1], q[0]}, "R6 tx_word");
    if (!dir_tx_i && host_rd_i && sz >= w) begin
      er = '0;
      for (int k = 0; k < w; k++) er[k*8 +: 8] = q[k];
      chk(host_rdata_o, er, "R2 rdata");
    end
    @(posedge clk_i);
    if (fifo_rst_i) begin
      q.delete(); m_err = 0; m_cnt = 0; m_evt = 0;
    end else begin
      base = (dir_tx_i != m_dir) ? 0 : m_cnt;
      moved = 0;
      if (dir_tx_i) begin
        if (host_wr_i) begin
          if (fr < w) m_err = 1;
          else for (int k = 0; k < w; k++) q.push_back(host_wdata_i[k*8 +: 8]);
        end
        if (tx_ready_i && sz >= 2) begin
          void'(q.pop_front()); void'(q.pop_front()); moved = 1;
        end
      end else begin
        if (host_rd_i) begin
          if (sz < w) m_err = 1;
          else for (int k = 0; k < w; k++) void'(q.pop_front());
        end
        if (rx_ready_i && fr >= 2) begin
          q.push_back(rx_word_i[7:0]); q.push_back(rx_word_i[15:8]); moved = 1;
        end
      end
      m_evt = 0;
      if (moved) begin
        base += 2;
        if (base >= (thr_512_i ? 64 : 32)) begin m_evt = 1; base = 0; end
      end
      m_cnt = base;
    end
    m_dir = dir_tx_i;
    @(negedge clk_i);
  endtask

  task automatic idle();
    host_wr_i = 0; host_rd_i = 0; tx_ready_i = 0; rx_ready_i = 0; fifo_rst_i = 0;
  endtask

  task automatic clear();
    idle(); fifo_rst_i = 1; step(); fifo_rst_i = 0;
  endtask

  task automatic hwrite(input int n);
    for (int i = 0; i < n; i++) begin
      host_wr_i = 1; host_wdata_i = rnd(); step();
    end
    host_wr_i = 0;
  endtask

  task automatic mix(input int n, input int wr_pct, input int rd_pct, input int sh_pct);
    for (int i = 0; i < n; i++) begin
      host_wdata_i = rnd(); rx_word_i = 16'(rnd());
      host_wr_i = (int'(rnd() % 100) < wr_pct);
      host_rd_i = (int'(rnd() % 100) < rd_pct);
      tx_ready_i = (int'(rnd() % 100) < sh_pct);
      rx_ready_i = (int'(rnd() % 100) < sh_pct);
      step();
    end
    idle();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    idle(); step();                                  // R1 reset state
    // R2 R3 R5: transmit, 4-byte width, fill to full and overflow
    dir_tx_i = 1; clear();
    hwrite(16);
    chk(32'(full_o), 32'd1, "R3 full after 64 bytes");
    hwrite(1);
    chk(32'(err_o), 32'd1, "R5 overflow sets err");
    host_rd_i = 1; step(); host_rd_i = 0;            // R6 read ignored in transmit
    chk(32'(full_o), 32'd1, "R6 host read ignored in transmit");
    clear();
    chk(32'(empty_o), 32'd1, "R1 empty after clear");
    chk(32'(err_o), 32'd0, "R1 err cleared");
    // R6 R8: drain with 256-bit threshold
    hwrite(16);
    tx_ready_i = 1;
    for (int i = 0; i < 20; i++) step();
    idle();
    // R8 with 512-bit threshold, refill while draining
    thr_512_i = 1;
    mix(300, 60, 0, 70);
    // R2 R3 R4: odd and small widths with wrap
    for (int c = 0; c < 4; c++) begin
      acc_w_i = 2'(c);
      mix(150, 50, 0, 40);
    end
    // R9: direction change clears the event count
    thr_512_i = 0; acc_w_i = 2'b00;
    clear(); hwrite(5);
    tx_ready_i = 1; for (int i = 0; i < 6; i++) step(); idle();
    dir_tx_i = 0;
    rx_ready_i = 1; rx_word_i = 16'hA55A;
    for (int i = 0; i < 40; i++) begin rx_word_i = 16'(rnd()); step(); end
    idle();
    chk(32'(full_o), 32'd1, "R7 receive fills buffer");
    hwrite(1);                                       // R7 write ignored in receive
    chk(32'(err_o), 32'd0, "R7 host write ignored in receive");
    // R4 R5: receive reads at each width, then underflow
    for (int c = 3; c >= 0; c--) begin
      acc_w_i = 2'(c);
      mix(120, 0, 50, 30);
    end
    acc_w_i = 2'b00;
    host_rd_i = 1; for (int i = 0; i < 20; i++) step(); idle();
    chk(32'(err_o), 32'd1, "R5 underflow sets err");
    // R10: clear together with traffic
    fifo_rst_i = 1; host_rd_i = 1; rx_ready_i = 1; step(); idle();
    chk(32'(empty_o), 32'd1, "R10 clear wins over traffic");
    dir_tx_i = 1; hwrite(3);
    fifo_rst_i = 1; host_wr_i = 1; tx_ready_i = 1; step(); idle();
    chk(32'(empty_o), 32'd1, "R10 clear wins in transmit");
    // random mixed run across both directions
    for (int r = 0; r < 6; r++) begin
      dir_tx_i = r[0]; acc_w_i = 2'(rnd()); thr_512_i = rnd() % 2 == 0;
      mix(200, 45, 45, 50);
    end
    idle(); step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule